// File: doc/BRIEF.md
# Two-Class Prioritized Interrupt Controller

This block gathers up to fifteen interrupt request lines, numbered 1 through 15, for one processor. It turns them into a single request level. A rising edge on a line latches a pending bit. Software can also raise a line directly through a force register. A mask register gates both sources. A class register places each line in either a high or a low priority group. Any unmasked request in the high group beats every request in the low group, whatever their line numbers. Within the chosen group, the highest-numbered line wins.

Software reaches the registers over a plain 32-bit bus with a byte address into a 256-byte window. Reads are combinational and writes take effect on the clock edge. When the processor takes an interrupt, it returns the serviced line number on an acknowledge input. The acknowledge clears that line's pending and force bits. The output level is held in a register. It changes only when the winning line changes, one clock after the state that selects it.

Top module: `irq_prio_ctl`

## Requirements
- R1: After reset, every register reads zero, `irq_level` is 0 and `irq_req` is low.
- R2: A rising edge on `irq_lines[n]` (n from 1 to 15) sets pending bit n. The bit stays set after the line falls.
- R3: A line counts as requesting when its pending bit or its force bit is set and its mask bit is also set. Masked lines never drive the output.
- R4: Within the selected class, `irq_level` reports the highest-numbered requesting line.
- R5: If any requesting line has its class bit set, only class-bit-set lines are considered, even when a line with a higher number and a clear class bit is requesting.
- R6: When no requesting line has its class bit set, the lines with a clear class bit are used.
- R7: With no requesting line, `irq_level` is 0 and `irq_req` is low. `irq_req` is high exactly when `irq_level` is nonzero.
- R8: Writing ones to the clear register at offset 0x0C clears those pending bits. The clear register always reads zero.
- R9: An acknowledge (`ack_valid` high for one cycle with `ack_line` = n) clears pending bit n and force bit n on that edge. An acknowledge with line 0 changes nothing.
- R10: Bit 0 of the mask, pending, force and class registers always reads zero and ignores writes.
- R11: The register offsets are: mask 0x00, pending 0x04 (writable), force 0x08, clear 0x0C, class 0x10. Any other offset in the window reads zero.
- R12: `irq_level` changes one clock after the register state that selects it. It does not change in the same cycle as that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 16 | Request lines, bit n is line n, bit 0 unused |
| bus_addr | input | 8 | Byte offset into the register window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| ack_valid | input | 1 | Processor acknowledge strobe |
| ack_line | input | 4 | Number of the serviced line |
| irq_level | output | 4 | Winning line number, 0 when none |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with its default fifteen lines and a 32-bit bus. This puts both the top line and line 1 within reach, and leaves the upper data bits unused so the zero-fill of reads can be seen. It sets up one line in the high class with a low number, against higher-numbered low-class lines, so that class order and number order disagree. It then removes requests one at a time by mask, acknowledge and clear, and watches the winner fall back through each group.

// File: rtl/irq_prio_ctl.sv
module irq_prio_ctl #(
  parameter int NUM_LINES = 15,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  localparam int VEC_W    = NUM_LINES + 1,
  localparam int LVL_W    = $clog2(VEC_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VEC_W-1:0]  irq_lines,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ack_valid,
  input  logic [LVL_W-1:0]  ack_line,
  output logic [LVL_W-1:0]  irq_level,
  output logic              irq_req
);

  localparam logic [ADDR_W-1:0] OFS_MASK  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_PEND  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFS_FORCE = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFS_CLEAR = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFS_CLASS = ADDR_W'(8'h10);
  localparam logic [VEC_W-1:0]  KEEP      = {{NUM_LINES{1'b1}}, 1'b0};

  logic [VEC_W-1:0] pend_q, force_q, mask_q, class_q, lines_d;
  logic [VEC_W-1:0] wvec, rise, ack_vec, eff, hi_vec, lo_vec, chosen;
  logic [LVL_W-1:0] win, level_q;
  logic             wr_mask, wr_pend, wr_force, wr_clear, wr_class;
  logic             unused_hi;

  assign wvec      = bus_wdata[VEC_W-1:0];
  assign unused_hi = ^bus_wdata[DATA_W-1:VEC_W];

  assign wr_mask  = bus_wr && (bus_addr == OFS_MASK);
  assign wr_pend  = bus_wr && (bus_addr == OFS_PEND);
  assign wr_force = bus_wr && (bus_addr == OFS_FORCE);
  assign wr_clear = bus_wr && (bus_addr == OFS_CLEAR);
  assign wr_class = bus_wr && (bus_addr == OFS_CLASS);

  assign rise = irq_lines & ~lines_d & KEEP;

  for (genvar i = 0; i < VEC_W; i++) begin : g_ack
    assign ack_vec[i] = ack_valid && (ack_line == LVL_W'(i)) && KEEP[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      force_q <= '0;
      mask_q  <= '0;
      class_q <= '0;
      lines_d <= '0;
      level_q <= '0;
    end else begin
      lines_d <= irq_lines;
      pend_q  <= (((wr_pend ? wvec : pend_q) & ~(wr_clear ? wvec : '0) & ~ack_vec) | rise) & KEEP;
      force_q <= (wr_force ? wvec : force_q) & ~ack_vec & KEEP;
      if (wr_mask)  mask_q  <= wvec & KEEP;
      if (wr_class) class_q <= wvec & KEEP;
      if (win != level_q) level_q <= win;
    end
  end

  assign eff    = (pend_q | force_q) & mask_q;
  assign hi_vec = eff & class_q;
  assign lo_vec = eff & ~class_q;
  assign chosen = (|hi_vec) ? hi_vec : lo_vec;

  always_comb begin
    win = '0;
    for (int i = 1; i < VEC_W; i++)
      if (chosen[i]) win = LVL_W'(i);
  end

  always_comb begin
    case (bus_addr)
      OFS_MASK:  bus_rdata = DATA_W'(mask_q);
      OFS_PEND:  bus_rdata = DATA_W'(pend_q);
      OFS_FORCE: bus_rdata = DATA_W'(force_q);
      OFS_CLASS: bus_rdata = DATA_W'(class_q);
      default:   bus_rdata = '0;
    endcase
  end

  assign irq_level = level_q;
  assign irq_req   = |level_q;

endmodule

// File: rtl/irq_prio_ctl_chk.sv
module irq_prio_ctl_chk #(
  parameter int VEC_W = 16,
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [VEC_W-1:0] pend_q,
  input logic [VEC_W-1:0] force_q,
  input logic [VEC_W-1:0] mask_q,
  input logic [VEC_W-1:0] class_q,
  input logic             ack_valid,
  input logic [LVL_W-1:0] ack_line,
  input logic [LVL_W-1:0] irq_level,
  input logic             irq_req
);
  logic [VEC_W-1:0] eff, eff_d, cls_d;
  assign eff = (pend_q | force_q) & mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eff_d <= '0;
      cls_d <= '0;
    end else begin
      eff_d <= eff;
      cls_d <= class_q;
    end
  end

  // R7
  idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eff == '0) |=> (irq_level == '0 && !irq_req));

  // R3
  level_backed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != '0) |-> eff_d[irq_level]);

  // R5
  class_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != '0 && (eff_d & cls_d) != '0) |-> cls_d[irq_level]);

  // R9
  ack_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_line != '0 && int'(ack_line) < VEC_W) |=> !force_q[$past(ack_line)]);

  // R10
  rsvd_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q[0] && !force_q[0] && !mask_q[0] && !class_q[0]);
endmodule

bind irq_prio_ctl irq_prio_ctl_chk #(.VEC_W(VEC_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pend_q(pend_q), .force_q(force_q),
  .mask_q(mask_q), .class_q(class_q), .ack_valid(ack_valid),
  .ack_line(ack_line), .irq_level(irq_level), .irq_req(irq_req)
);

// File: tb/irq_prio_ctl_test.sv
module irq_prio_ctl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] irq_lines = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ack_valid = 0;
  logic [3:0]  ack_line = '0;
  logic [3:0]  irq_level;
  logic        irq_req;

  int n_chk = 0;
  int n_bad = 0;

  irq_prio_ctl uut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ack_valid(ack_valid), .ack_line(ack_line), .irq_level(irq_level),
    .irq_req(irq_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic lvl_chk(string req, logic [3:0] exp);
    chk(req, {28'd0, irq_level}, {28'd0, exp});
    chk(req, {31'd0, irq_req}, {31'd0, exp != 0});
  endtask

  task automatic t_reset();
    rd_chk("R1 mask", 8'h00, 0);
    rd_chk("R1 pend", 8'h04, 0);
    rd_chk("R1 force", 8'h08, 0);
    rd_chk("R1 class", 8'h10, 0);
    lvl_chk("R1 level", 0);
  endtask

  task automatic t_reserved();
    wr(8'h00, 32'hFFFF_FFFF);
    rd_chk("R10 mask bit0", 8'h00, 32'h0000_FFFE);
    settle();
    lvl_chk("R7 nothing pending", 0);
  endtask

  task automatic t_edge();
    @(negedge clk);
    irq_lines[5] = 1;
    repeat (2) @(negedge clk);
    rd_chk("R2 pend set", 8'h04, 32'h20);
    lvl_chk("R2 level", 5);
    irq_lines[5] = 0;
    repeat (2) @(negedge clk);
    rd_chk("R2 pend held", 8'h04, 32'h20);
    lvl_chk("R2 level held", 5);
  endtask

  task automatic t_mask_force();
    wr(8'h00, 32'hFFDE);
    settle();
    lvl_chk("R3 masked", 0);
    wr(8'h08, 32'h0008);
    settle();
    lvl_chk("R3 force", 3);
    wr(8'h00, 32'hFFFE);
    settle();
    lvl_chk("R4 5 over 3", 5);
  endtask

  task automatic t_highest();
    wr(8'h04, 32'h0228);
    lvl_chk("R12 no same-cycle change", 5);
    settle();
    lvl_chk("R4 highest", 9);
  endtask

  task automatic t_class();
    wr(8'h10, 32'h0008);
    settle();
    lvl_chk("R5 high class wins", 3);
    rd_chk("R11 class offset", 8'h10, 32'h0008);
  endtask

  task automatic t_ack();
    @(negedge clk);
    ack_valid = 1; ack_line = 4'd3;
    @(negedge clk);
    ack_valid = 0; ack_line = 0;
    rd_chk("R9 pend cleared", 8'h04, 32'h0220);
    rd_chk("R9 force cleared", 8'h08, 32'h0);
    settle();
    lvl_chk("R6 low class fallback", 9);
    @(negedge clk);
    ack_valid = 1; ack_line = 4'd0;
    @(negedge clk);
    ack_valid = 0;
    rd_chk("R9 line0 no effect", 8'h04, 32'h0220);
  endtask

  task automatic t_clear();
    wr(8'h0C, 32'h0200);
    rd_chk("R8 pend after clear", 8'h04, 32'h0020);
    rd_chk("R8 clear reads zero", 8'h0C, 32'h0);
    settle();
    lvl_chk("R8 level", 5);
    rd_chk("R11 unmapped", 8'h40, 32'h0);
    wr(8'h0C, 32'hFFFF);
    settle();
    rd_chk("R7 pend empty", 8'h04, 32'h0);
    lvl_chk("R7 idle", 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL all: watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_reserved();
    t_edge();
    t_mask_force();
    t_highest();
    t_class();
    t_ack();
    t_clear();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule